// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps the time of day on a 12-hour face as four packed-BCD bytes: tenths of a second, seconds, minutes and hours. Bit 7 of the hours byte marks PM. The clock is driven by a line-frequency tick input. A divider counts those ticks, five or six of them, into one tenth of a second. A second set of four bytes holds an alarm time.

A small register port reads and writes the four time bytes. A select input sends each write either to the running clock or to the alarm. Reads are made coherent by a snapshot: reading hours freezes a copy of all four bytes, and reading tenths releases it. Writes are made coherent by a stop: writing hours halts the clock, and writing tenths starts it again. When the running clock equals the alarm after a write or an advance, the block pulses an interrupt line.

Top module: `tod_clock`

## Requirements
- R1: After reset the clock holds 12:00:00.0 AM (hours 0x12, minutes, seconds and tenths 0x00), the alarm holds all zeros, the clock is stopped, and `alarmIrq` is low.
- R2: `addr` selects the byte: 0 tenths, 1 seconds, 2 minutes, 3 hours. A write (`wrEn`) goes to the alarm when `alarmSel` is 1 and to the clock when it is 0. The byte takes the value at the next clock edge, and the other set is left unchanged.
- R3: Every written hours value is ANDed with 0x9F. For a clock write only, if the low five bits then equal 0x12, bit 7 is inverted before the value is stored. Alarm hours are stored without this inversion.
- R4: A clock write to hours stops the clock. A clock write to tenths starts it. A stopped clock does not advance, whatever ticks arrive.
- R5: While the clock runs, every sixth `lineTick` pulse advances it by one tenth when `sel60` is 1, and every fifth when `sel60` is 0. The divider count is cleared while the clock is stopped.
- R6: Counting is in BCD. Tenths wrap from 9 to 0 and carry into seconds. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours.
- R7: A carry into hours steps 01 through 11 in BCD. Hours go from 11 to 12 with bit 7 inverted, and from 12 to 01 with bit 7 kept.
- R8: `rdData` shows the addressed byte in the same cycle that `rdEn` is high. A read of hours while no snapshot is held captures all four clock bytes and holds them. While the snapshot is held, reads of any byte return the captured value. A read of tenths returns the held value and then releases the snapshot. With no snapshot held, reads return the live clock.
- R9: The clock keeps advancing while a snapshot is held.
- R10: In the cycle after any write or clock advance, `alarmIrq` is high for one cycle if the clock is running and all four clock bytes equal the alarm bytes. It stays low when the clock is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineTick | input | 1 | One-cycle pulse per line-frequency period |
| sel60 | input | 1 | 1: six ticks per tenth, 0: five |
| alarmSel | input | 1 | 1: writes go to the alarm, 0: writes go to the clock |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 2 | Byte select: 0 tenths, 1 seconds, 2 minutes, 3 hours |
| wrData | input | 8 | Write data (BCD) |
| rdData | output | 8 | Read data, combinational from the addressed byte |
| alarmIrq | output | 1 | Alarm-match pulse |

## Verification
Read data is combinational, so the bench samples `rdData` one nanosecond after it raises `rdEn` on a falling edge, in the same cycle. A write or the tick that completes a tenth lands at the next rising edge. Its effect on the bytes shows on a later read, and its alarm pulse is due in the half cycle that follows that edge. The bench therefore samples `alarmIrq` at the falling edge right after the write or final tick, and once more a cycle later to confirm the pulse has dropped. Counting cases run from a vector table, each one loading a start time, applying whole tenths, and reading back in hours-first order.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int BYTES  = 4;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] IDX_TENTHS = 2'd0;
  localparam logic [ADDR_W-1:0] IDX_HOURS  = 2'd3;
  localparam logic [7:0] HOUR_MASK = 8'h9F;

  typedef struct packed {
    logic advance;   // step the time by one tenth
    logic wrClock;   // write addressed clock byte
    logic wrAlarm;   // write addressed alarm byte
    logic takeSnap;  // capture read snapshot
  } todStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'h9) bcdInc = {v[7:4] + 4'h1, 4'h0};
    else                bcdInc = v + 8'h01;
  endfunction
endpackage

// File: rtl/tod_ctrl.sv
`timescale 1ns/1ps
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int DIV_LO = 5,
  parameter int DIV_HI = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineTick,
  input  logic              sel60,
  input  logic              alarmSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              match,
  output todStrobe_t        strobe,
  output logic              snapHeld,
  output logic              running,
  output logic              alarmIrq
);
  localparam int CNT_W = $clog2(DIV_HI + 1);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);

  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] lastCnt;
  logic clockWrite;
  logic tickDone;
  logic pending;

  assign lastCnt    = sel60 ? LAST_HI : LAST_LO;
  assign clockWrite = wrEn & ~alarmSel;
  assign tickDone   = running & lineTick & (preCnt >= lastCnt);

  always_comb begin
    strobe.advance  = tickDone & ~clockWrite;  // a clock write wins the cycle
    strobe.wrClock  = clockWrite;
    strobe.wrAlarm  = wrEn & alarmSel;
    strobe.takeSnap = rdEn & ~snapHeld & (addr == IDX_HOURS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      preCnt   <= '0;
      snapHeld <= 1'b0;
      pending  <= 1'b0;
    end else begin
      if (clockWrite && addr == IDX_HOURS)       running <= 1'b0;
      else if (clockWrite && addr == IDX_TENTHS) running <= 1'b1;

      if (!running)      preCnt <= '0;
      else if (lineTick) preCnt <= (preCnt >= lastCnt) ? '0 : preCnt + 1'b1;

      if (rdEn && addr == IDX_HOURS)       snapHeld <= 1'b1;
      else if (rdEn && addr == IDX_TENTHS) snapHeld <= 1'b0;

      pending <= wrEn | strobe.advance;
    end
  end

  assign alarmIrq = pending & running & match;

  assert_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !alarmSel && addr == IDX_HOURS) |=> !running);
  assert_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !alarmSel && addr == IDX_TENTHS) |=> running);
  assert_prescale_R5: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= LAST_HI);
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    (alarmIrq && !wrEn && !lineTick) |=> !alarmIrq);
endmodule

// File: rtl/tod_datapath.sv
`timescale 1ns/1ps
module tod_datapath
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  todStrobe_t        strobe,
  input  logic              snapHeld,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              match
);
  logic [BYTES-1:0][7:0] clockB, alarmB, snapB, nextB;
  logic [BYTES-1:0]      carry;
  logic [7:0] hourIn, hourClk;
  logic [4:0] hourLow;

  assign hourIn  = wrData & HOUR_MASK;
  assign hourClk = (hourIn[4:0] == 5'h12) ? (hourIn ^ 8'h80) : hourIn;
  assign hourLow = clockB[IDX_HOURS][4:0];

  always_comb begin
    nextB    = clockB;
    carry    = '0;
    carry[0] = 1'b1;
    for (int i = 0; i < BYTES - 1; i++) begin
      if (carry[i]) begin
        if (clockB[i] == ((i == 0) ? 8'h09 : 8'h59)) begin
          nextB[i]   = 8'h00;
          carry[i+1] = 1'b1;
        end else begin
          nextB[i] = bcdInc(clockB[i]);
        end
      end
    end
    if (carry[BYTES-1]) begin
      if (hourLow == 5'h11)
        nextB[IDX_HOURS] = {~clockB[IDX_HOURS][7], 2'b00, 5'h12};
      else if (hourLow == 5'h12)
        nextB[IDX_HOURS] = {clockB[IDX_HOURS][7], 2'b00, 5'h01};
      else if (hourLow[3:0] == 4'h9)
        nextB[IDX_HOURS] = {clockB[IDX_HOURS][7], 2'b00, 5'h10};
      else
        nextB[IDX_HOURS] = {clockB[IDX_HOURS][7], 2'b00, hourLow + 5'h01};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clockB <= {8'h12, 8'h00, 8'h00, 8'h00};
      alarmB <= '0;
      snapB  <= '0;
    end else begin
      if (strobe.wrClock)
        clockB[addr] <= (addr == IDX_HOURS) ? hourClk : wrData;
      else if (strobe.advance)
        clockB <= nextB;
      if (strobe.wrAlarm)
        alarmB[addr] <= (addr == IDX_HOURS) ? hourIn : wrData;
      if (strobe.takeSnap)
        snapB <= clockB;
    end
  end

  assign rdData = snapHeld ? snapB[addr] : clockB[addr];
  assign match  = (clockB == alarmB);

  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    snapHeld |=> $stable(snapB));
  assert_tenths_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.wrClock && clockB[0] == 8'h09) |=> clockB[0] == 8'h00);
  assert_hour_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    clockB[IDX_HOURS][6:5] == 2'b00 && alarmB[IDX_HOURS][6:5] == 2'b00);
endmodule

// File: rtl/tod_clock.sv
`timescale 1ns/1ps
module tod_clock
  import tod_pkg::*;
#(
  parameter int DIV_LO = 5,
  parameter int DIV_HI = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineTick,
  input  logic        sel60,
  input  logic        alarmSel,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        alarmIrq
);
  todStrobe_t strobe;
  logic snapHeld, running, match;

  tod_ctrl #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineTick(lineTick), .sel60(sel60),
    .alarmSel(alarmSel), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .match(match), .strobe(strobe), .snapHeld(snapHeld),
    .running(running), .alarmIrq(alarmIrq)
  );

  tod_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .snapHeld(snapHeld),
    .addr(addr), .wrData(wrData), .rdData(rdData), .match(match)
  );
endmodule

// File: tb/tod_clock_bench.sv
`timescale 1ns/1ps
module tod_clock_bench;
  localparam int CLK_PERIOD = 8;
  localparam int NVEC = 10;
  // {hours, minutes, seconds, tenths}
  localparam logic [31:0] VEC_START [NVEC] = '{
    32'h01000000, 32'h01000009, 32'h01005909, 32'h01595909, 32'h09595909,
    32'h11595909, 32'h92595909, 32'h91595909, 32'h12595909, 32'h01000008};
  localparam int VEC_STEPS [NVEC] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 3};
  localparam logic [31:0] VEC_EXP [NVEC] = '{
    32'h01000001, 32'h01000100, 32'h01010000, 32'h02000000, 32'h10000000,
    32'h92000000, 32'h81000000, 32'h12000000, 32'h01000000, 32'h01000101};

  logic clk = 1'b0, rstN = 1'b0, lineTick = 1'b0, sel60 = 1'b0;
  logic alarmSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic alarmIrq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  tod_clock u_tod_clock (
    .clk(clk), .rstN(rstN), .lineTick(lineTick), .sel60(sel60),
    .alarmSel(alarmSel), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .alarmIrq(alarmIrq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic toAlarm);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; alarmSel = toAlarm;
    @(negedge clk);
    wrEn = 1'b0; alarmSel = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); lineTick = 1'b1;
    @(negedge clk); lineTick = 1'b0;
  endtask

  task automatic tenths(input int n);
    for (int k = 0; k < n * (sel60 ? 6 : 5); k++) tick();
  endtask

  function automatic logic [7:0] hourEnc(input logic [7:0] h);
    return (h[4:0] == 5'h12) ? (h ^ 8'h80) : h;
  endfunction

  task automatic setTime(input logic [31:0] t, input logic toAlarm);
    wr(2'd3, toAlarm ? t[31:24] : hourEnc(t[31:24]), toAlarm);
    wr(2'd2, t[23:16], toAlarm);
    wr(2'd1, t[15:8], toAlarm);
    wr(2'd0, t[7:0], toAlarm);
  endtask

  task automatic getTime(output logic [31:0] t);
    logic [7:0] b;
    rd(2'd3, b); t[31:24] = b;
    rd(2'd2, b); t[23:16] = b;
    rd(2'd1, b); t[15:8]  = b;
    rd(2'd0, b); t[7:0]   = b;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] t;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, and stopped
    check("R1 irq low", {31'b0, alarmIrq}, 32'h0);
    getTime(t);
    check("R1 reset time", t, 32'h12000000);
    tenths(2);
    getTime(t);
    check("R1 stopped after reset", t, 32'h12000000);

    // R6 R7: counting table, divide by five
    for (int v = 0; v < NVEC; v++) begin
      setTime(VEC_START[v], 1'b0);
      tenths(VEC_STEPS[v]);
      getTime(t);
      check($sformatf("R6/R7 vector %0d", v), t, VEC_EXP[v]);
    end

    // R3: masking and PM inversion on clock hours
    wr(2'd3, 8'hE5, 1'b0); rd(2'd3, b); rd(2'd0, t[7:0]);
    check("R3 mask", {24'b0, b}, 32'h85);
    wr(2'd3, 8'h72, 1'b0); rd(2'd3, b); rd(2'd0, t[7:0]);
    check("R3 mask then invert", {24'b0, b}, 32'h92);
    wr(2'd3, 8'h92, 1'b0); rd(2'd3, b); rd(2'd0, t[7:0]);
    check("R3 invert to AM", {24'b0, b}, 32'h12);

    // R4: hours write stops, tenths write restarts
    setTime(32'h03101005, 1'b0);
    wr(2'd3, 8'h03, 1'b0);
    tenths(3);
    getTime(t);
    check("R4 stopped by hours write", t, 32'h03101005);
    wr(2'd0, 8'h05, 1'b0);
    tenths(1);
    getTime(t);
    check("R4 restarted by tenths write", t, 32'h03101006);

    // R2: alarm write leaves clock unchanged
    setTime(32'h04050607, 1'b1);
    getTime(t);
    check("R2 clock untouched by alarm write", t, 32'h03101006);

    // R5: divide by six
    sel60 = 1'b1;
    setTime(32'h01000000, 1'b0);
    repeat (5) tick();
    getTime(t);
    check("R5 five ticks not enough at sel60", t, 32'h01000000);
    tick();
    getTime(t);
    check("R5 sixth tick advances", t, 32'h01000001);
    sel60 = 1'b0;

    // R8 R9: snapshot holds while clock runs
    setTime(32'h01000000, 1'b0);
    rd(2'd3, b);
    check("R8 hours read", {24'b0, b}, 32'h01);
    tenths(1);
    rd(2'd1, b);
    check("R8 held seconds", {24'b0, b}, 32'h00);
    rd(2'd0, b);
    check("R8 held tenths", {24'b0, b}, 32'h00);
    rd(2'd0, b);
    check("R9 live tenths after release", {24'b0, b}, 32'h01);

    // R10 + R3: alarm hours stored without inversion, match on advance
    wr(2'd3, 8'h72, 1'b1);
    wr(2'd2, 8'h00, 1'b1);
    wr(2'd1, 8'h00, 1'b1);
    wr(2'd0, 8'h01, 1'b1);
    setTime(32'h12000000, 1'b0);
    check("R10 no irq before match", {31'b0, alarmIrq}, 32'h0);
    repeat (4) tick();
    tick();
    check("R10 irq on advance match", {31'b0, alarmIrq}, 32'h1);
    @(negedge clk);
    check("R10 irq is one cycle", {31'b0, alarmIrq}, 32'h0);
    // match on write while running (clock now 12:00:00.1, stays there until next tenth)
    wr(2'd0, 8'h01, 1'b0);
    check("R10 irq on write match", {31'b0, alarmIrq}, 32'h1);
    @(negedge clk);
    check("R10 irq dropped", {31'b0, alarmIrq}, 32'h0);
    // stopped clock: no irq even when equal
    wr(2'd3, 8'h92, 1'b0);
    check("R10 no irq when stopped", {31'b0, alarmIrq}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule